// File: doc/BRIEF.md
# Gated Event Counter

This block counts rising edges of an asynchronous event input, but only while a gate is open. The gate comes from one of two sources. One is an external gate pin. The other is the output of a PWM generator elsewhere on the chip. A select input chooses between them. Both the event input and the external gate pin pass through multi-flop synchronisers into the block's clock domain. The PWM output is already synchronous, so by default it skips that delay.

The block forms the counted signal as the AND of the synchronised event and the selected gate. It then increments a 16-bit counter on each rising edge of that product. The gate cuts the counted signal abruptly. If the gate opens while the event is already high, the product rises and that counts once. If the gate closes while the event is high, the pulse is cut short and nothing is counted. The total can therefore differ from the true number of events by at most one per gate transition.

On wrap, the counter sets a sticky overflow flag. A synchronous clear zeroes both the count and the flag.

Top module: `gated_event_counter`

## Requirements
- R1: With `gate_sel` = 0, the synchronised `gate_pin` is the gate, and `pwm_gate` has no effect on the count.
- R2: With `gate_sel` = 1, `pwm_gate` is the gate, and `gate_pin` has no effect on the count.
- R3: While the selected gate is 0, the count holds its value whatever `evt_in` does.
- R4: With the gate open, a 0-to-1 change of `evt_in` increments the count exactly once. The count changes on the third rising clock edge after the new level is applied: two synchroniser flops, then the counter register.
- R5: If the gate goes from 0 to 1 while the synchronised event is 1, the count increments once. On the PWM path, the count changes on the first clock edge that sees the new gate value.
- R6: Closing the gate, and a 1-to-0 change of `evt_in`, never increment the count.
- R7: One increment from 16'hFFFF wraps the count to 16'h0000 and sets `ovf` to 1 on the same clock edge.
- R8: Once set, `ovf` stays 1 through further increments until a clear.
- R9: `clr` = 1 at a clock edge sets the count to 0 and `ovf` to 0. It wins over an increment that would occur at the same edge, and that edge is not counted later.
- R10: After reset, `count` is 0 and `ovf` is 0.
- R11: On the pin path, reopening the gate while the event is high shows in the count on the third rising clock edge after `gate_pin` rises, because the pin has its own two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Asynchronous event input to be counted |
| gate_pin | input | 1 | Asynchronous external gate, 1 = open |
| pwm_gate | input | 1 | Synchronous PWM output used as gate, 1 = open |
| gate_sel | input | 1 | Gate source: 0 = gate_pin, 1 = pwm_gate |
| clr | input | 1 | Synchronous clear of count and overflow |
| count | output | 16 | Current count value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach from the ports is the counter wrap: at most one increment is possible every two clocks, so the count must be driven through all 65,536 values. The stimulus holds the event input high, selects the PWM gate and toggles `pwm_gate` every clock. Every reopening of the gate counts once, which sweeps the full range in about 131k cycles. The gate-reopen corner is approached the same way: the event is raised while the gate is closed, and the count is then watched at the exact edge the gate reaches the counter.

// File: rtl/gec_pkg.sv
package gec_pkg;

   typedef enum logic {
      GATE_FROM_PIN = 1'b0,
      GATE_FROM_PWM = 1'b1
   } gate_src_e;

   localparam int unsigned GEC_DEF_CNT_W  = 16;
   localparam int unsigned GEC_DEF_STAGES = 2;

endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      assert (STAGES >= 2) else $error("gec_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("gec_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_async;
   end

   for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[gi] <= '0;
         else        stg[gi] <= stg[gi-1];
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/gec_gate_edge.sv
module gec_gate_edge
   import gec_pkg::*;
#(
   parameter bit          PWM_SYNC = 1'b0,
   parameter int unsigned STAGES   = GEC_DEF_STAGES
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      evt_s,
   input  logic      pin_s,
   input  logic      pwm_raw,
   input  gate_src_e src,
   output logic      gate_eff,
   output logic      rise
);

   logic pwm_use;
   logic prod;
   logic prod_q;

   if (PWM_SYNC) begin : g_pwm_sync
      gec_sync #(.WIDTH(1), .STAGES(STAGES)) u_pwm_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_async (pwm_raw),
         .q_sync  (pwm_use)
      );
   end else begin : g_pwm_direct
      assign pwm_use = pwm_raw;
   end

   always_comb begin
      unique case (src)
         GATE_FROM_PWM: gate_eff = pwm_use;
         default:       gate_eff = pin_s;
      endcase
   end

   assign prod = evt_s & gate_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= 1'b0;
      else        prod_q <= prod;
   end

   assign rise = prod & ~prod_q;

endmodule

// File: rtl/gec_count.sv
module gec_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W:0] sum;

   assign sum = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         count <= sum[CNT_W-1:0];
         if (sum[CNT_W]) ovf <= 1'b1;
      end
   end

   // R7: an increment from all ones wraps to zero and raises overflow
   p_wrap_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && count == CNT_MAX) |=> (count == '0 && ovf));

   // R8: overflow is sticky until cleared
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
   import gec_pkg::*;
#(
   parameter int unsigned CNT_W    = GEC_DEF_CNT_W,
   parameter int unsigned STAGES   = GEC_DEF_STAGES,
   parameter bit          PWM_SYNC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_in,
   input  logic             gate_pin,
   input  logic             pwm_gate,
   input  logic             gate_sel,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam int unsigned SYNC_W = 2;

   initial begin
      assert (CNT_W >= 2) else $error("gated_event_counter: CNT_W must be at least 2");
      assert (STAGES >= 2) else $error("gated_event_counter: STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] async_in;
   logic [SYNC_W-1:0] sync_out;
   logic              evt_s;
   logic              pin_s;
   logic              gate_eff;
   logic              rise;
   gate_src_e         src;

   assign async_in = {gate_pin, evt_in};
   assign evt_s    = sync_out[0];
   assign pin_s    = sync_out[1];
   assign src      = gate_src_e'(gate_sel);

   gec_sync #(.WIDTH(SYNC_W), .STAGES(STAGES)) u_in_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (async_in),
      .q_sync  (sync_out)
   );

   gec_gate_edge #(.PWM_SYNC(PWM_SYNC), .STAGES(STAGES)) u_gate_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_s    (evt_s),
      .pin_s    (pin_s),
      .pwm_raw  (pwm_gate),
      .src      (src),
      .gate_eff (gate_eff),
      .rise     (rise)
   );

   gec_count #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (rise),
      .count (count),
      .ovf   (ovf)
   );

   // R3: a closed gate leaves the count untouched
   p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_eff && !clr) |=> $stable(count));

   // R4: the count never moves by more than one per clock
   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

   // R9: clear empties count and overflow on the next edge
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !ovf));

endmodule

// File: tb/gated_event_counter_tb_top.sv
`timescale 1ns/1ps
module gated_event_counter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_in = 1'b0;
   logic        gate_pin = 1'b0;
   logic        pwm_gate = 1'b0;
   logic        gate_sel = 1'b0;
   logic        clr = 1'b0;
   logic [15:0] count;
   logic        ovf;

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;
   logic [15:0] exp_cnt = '0;

   always #2 clk = ~clk;

   gated_event_counter dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_in),
      .gate_pin (gate_pin),
      .pwm_gate (pwm_gate),
      .gate_sel (gate_sel),
      .clr      (clr),
      .count    (count),
      .ovf      (ovf)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_cnt(input string req, input logic [15:0] e);
      n_chk++;
      if (count !== e) begin
         n_fail++;
         $display("FAIL %s count actual=%h expected=%h", req, count, e);
      end
   endtask

   task automatic chk_ovf(input string req, input logic e);
      n_chk++;
      if (ovf !== e) begin
         n_fail++;
         $display("FAIL %s ovf actual=%b expected=%b", req, ovf, e);
      end
   endtask

   task automatic pulse_evt();
      evt_in = 1'b1;
      step(4);
      evt_in = 1'b0;
      step(4);
   endtask

   task automatic do_clear();
      clr = 1'b1;
      step(1);
      clr = 1'b0;
      exp_cnt = '0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      // R10: reset state
      chk_cnt("R10", 16'h0000);
      chk_ovf("R10", 1'b0);
      rst_n = 1'b1;
      step(2);

      // R1 / R2 / R3: sweep select and both gate levels
      for (int s = 0; s < 2; s++) begin
         for (int g = 0; g < 4; g++) begin
            gate_sel = s[0];
            gate_pin = g[0];
            pwm_gate = g[1];
            step(4);
            for (int k = 0; k < 3; k++) pulse_evt();
            if ((s == 0 && g[0]) || (s == 1 && g[1])) exp_cnt = exp_cnt + 16'd3;
            chk_cnt(s == 0 ? "R1/R3" : "R2/R3", exp_cnt);
         end
      end

      // R4: latency of an event edge through the synchroniser
      gate_sel = 1'b1; pwm_gate = 1'b1; gate_pin = 1'b0;
      step(2);
      evt_in = 1'b1;
      step(2);
      chk_cnt("R4", exp_cnt);
      step(1);
      exp_cnt = exp_cnt + 16'd1;
      chk_cnt("R4", exp_cnt);
      step(4);
      chk_cnt("R4", exp_cnt);
      evt_in = 1'b0;
      step(4);
      // R6: a falling event edge does not count
      chk_cnt("R6", exp_cnt);

      // R5: PWM gate reopens while the event is high
      pwm_gate = 1'b0;
      evt_in = 1'b1;
      step(4);
      chk_cnt("R3", exp_cnt);
      pwm_gate = 1'b1;
      step(1);
      exp_cnt = exp_cnt + 16'd1;
      chk_cnt("R5", exp_cnt);
      step(3);
      chk_cnt("R5", exp_cnt);
      pwm_gate = 1'b0;
      step(2);
      // R6: closing the gate does not count
      chk_cnt("R6", exp_cnt);
      evt_in = 1'b0;
      step(4);
      chk_cnt("R6", exp_cnt);

      // R11: pin gate reopens while the event is high
      gate_sel = 1'b0; gate_pin = 1'b0; pwm_gate = 1'b1;
      evt_in = 1'b1;
      step(4);
      chk_cnt("R1", exp_cnt);
      gate_pin = 1'b1;
      step(2);
      chk_cnt("R11", exp_cnt);
      step(1);
      exp_cnt = exp_cnt + 16'd1;
      chk_cnt("R11", exp_cnt);
      gate_pin = 1'b0;
      evt_in = 1'b0;
      step(4);

      // R9: clear wins over a simultaneous increment
      gate_sel = 1'b1; pwm_gate = 1'b0; evt_in = 1'b1;
      step(4);
      clr = 1'b1;
      pwm_gate = 1'b1;
      step(1);
      clr = 1'b0;
      exp_cnt = '0;
      chk_cnt("R9", exp_cnt);
      chk_ovf("R9", 1'b0);
      step(3);
      chk_cnt("R9", exp_cnt);

      // R7: full sweep to the wrap point by toggling the PWM gate
      pwm_gate = 1'b0;
      step(1);
      for (int i = 0; i < 65535; i++) begin
         pwm_gate = 1'b1;
         step(1);
         pwm_gate = 1'b0;
         step(1);
      end
      chk_cnt("R7", 16'hFFFF);
      chk_ovf("R7", 1'b0);
      pwm_gate = 1'b1;
      step(1);
      chk_cnt("R7", 16'h0000);
      chk_ovf("R7", 1'b1);
      pwm_gate = 1'b0;
      step(1);

      // R8: overflow is sticky across later increments
      for (int i = 0; i < 2; i++) begin
         pwm_gate = 1'b1;
         step(1);
         pwm_gate = 1'b0;
         step(1);
      end
      chk_cnt("R8", 16'h0002);
      chk_ovf("R8", 1'b1);
      do_clear();
      chk_cnt("R9", 16'h0000);
      chk_ovf("R9", 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule